// File: doc/BRIEF.md
# Synchronous Burst SRAM Address and Write Front End

This block is the clocked front end of a small burst-capable static memory. On every rising clock edge it samples the address, the write data, two chip enables, two address strobes, a burst-advance input and the write controls. Either strobe can start a new burst from the external address. Later word positions come from an internal 2-bit counter that steps only when the advance input is asserted.

The low two address bits follow either an interleaved order (start bits XOR count) or a linear order (start bits plus count, modulo 4), chosen by a mode input. The upper bits stay fixed for the whole burst. The block holds a parameterised word array split into byte lanes, which are two 9-bit lanes for an 18-bit word by default. It decodes the global write and the per-lane write selects into lane write enables. A read is combinational from the registered address, so `rdata` shows the word at `cur_addr` right after the edge that set the address.

A cycle started by the processor-side strobe is always a read. Writes happen only on cycles started by the controller-side strobe, or on cycles that the advance input moves forward.

Top module: `burst_sram_front`

## Requirements
- R1: While `rst_n` is low, `busy` is 0, `cur_addr` is 0 and `lane_we` is 0.
- R2: A cycle with `adsp_n`=0, `ce1_n`=0 and `ce2`=1 loads `addr` into `cur_addr` and sets `busy`. It writes nothing (`lane_we`=0, stored data unchanged), whatever the write controls are.
- R3: A cycle with `adsc_n`=0 and `adsp_n`=1, with the chip selected (`ce1_n`=0 and `ce2`=1), loads `addr` and sets `busy`. It writes the lanes given by the write decode.
- R4: When both strobes are low with `ce1_n`=0, the processor-side strobe wins, so the cycle is a read. When `ce1_n`=1, `adsp_n` is ignored: with `adsc_n`=1 and `adv_n`=1, `cur_addr` and `busy` keep their values.
- R5: A strobe-started cycle without chip select clears `busy` and writes nothing. This covers `adsc_n`=0 with `ce1_n`=1 or `ce2`=0, and `adsp_n`=0 with `ce1_n`=0 and `ce2`=0. While `busy`=0, `adv_n`=0 neither changes `cur_addr` nor writes.
- R6: While `busy`=1 with both strobes high, `adv_n`=0 steps the burst count by one and allows a write at the new address. `adv_n`=1 keeps `cur_addr` unchanged and writes nothing.
- R7: With `burst_lin`=0 the low two bits of `cur_addr` equal the start bits XOR the count.
- R8: With `burst_lin`=1 the low two bits equal (start bits + count) mod 4. In both orders the upper bits keep their start value, and the fourth advance returns to the start address.
- R9: With `gw_n`=1 and `bwe_n`=0, lane i is written exactly when `bsel_n[i]`=0, and the other lanes keep their data. With `gw_n`=1 and `bwe_n`=1 no lane is written. Lane i occupies `wdata`/`rdata` bits [9i+8:9i].
- R10: `gw_n`=0 on a write-permitted cycle writes every lane, whatever `bwe_n` and `bsel_n` are.
- R11: `lane_we` shows the lanes written at the last edge. After that edge `rdata` equals the stored word at `cur_addr`, including any data just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | External word address |
| wdata | input | LANE_W*LANES | Write data, lane 0 in the low bits |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| burst_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| busy | output | 1 | A selected burst is in progress |
| cur_addr | output | ADDR_W | Address of the current word |
| lane_we | output | LANES | Lanes written at the last edge |
| rdata | output | LANE_W*LANES | Word stored at `cur_addr` |

## Verification
The bench uses the default sizes: 6 address bits (64 words) and two 9-bit lanes. With these sizes it can fill and read back every word of the array against its own model. It sweeps all four start offsets in both burst orders through a full wrap of four advances. It also sweeps all sixteen combinations of global write, byte-write enable and the two lane selects. Directed cycles then cover strobe priority, the ignored strobe, deselection, suspended bursts and writes on advance cycles.

// File: rtl/burst_sram_front.sv
module burst_sram_front #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              burst_lin,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bsel_n,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LANES-1:0]  lane_we,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              busy_d;
  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [1:0] burst_lo(input logic [1:0] s, input logic [1:0] c, input logic lin);
    return lin ? s + c : s ^ c;
  endfunction

  wire sel_now = !ce1_n && ce2;
  wire p_go    = !adsp_n && !ce1_n;
  wire c_go    = !adsc_n && !p_go;
  wire a_go    = !adv_n && busy && !p_go && adsc_n;
  wire wr_ok   = (c_go && sel_now) || a_go;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    busy_d = busy;
    if (p_go) begin
      base_d = addr;
      cnt_d  = 2'd0;
      busy_d = ce2;
    end else if (c_go) begin
      base_d = addr;
      cnt_d  = 2'd0;
      busy_d = sel_now;
    end else if (a_go) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  wire [LANES-1:0] lane_mask = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bsel_n : '0);
  wire [LANES-1:0] wr_lanes  = wr_ok ? lane_mask : '0;
  wire [ADDR_W-1:0] eff_addr = {base_d[ADDR_W-1:2], burst_lo(base_d[1:0], cnt_d, burst_lin)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      cnt_q   <= '0;
      busy    <= 1'b0;
      lane_we <= '0;
    end else begin
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      busy    <= busy_d;
      lane_we <= wr_lanes;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_lanes[i]) mem[eff_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_q, burst_lin)};
  assign rdata    = mem[cur_addr];

  // R2
  p_start_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce1_n) |=> (lane_we == '0));

  // R5
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && adsp_n && !(!ce1_n && ce2)) |=> (!busy && lane_we == '0));

  // R6
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && adsp_n && adsc_n && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && adsc_n && adv_n && (adsp_n || ce1_n)) |=> ($stable(cur_addr) && lane_we == '0));

  // R10
  gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && adsp_n && !ce1_n && ce2 && !gw_n) |=> (lane_we == {LANES{1'b1}}));

  // R11
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> busy);

endmodule

// File: tb/burst_sram_front_tb.sv
module burst_sram_front_tb;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = 0;
  logic [DW-1:0] wdata = 0;
  logic ce1_n = 0, ce2 = 1, adsp_n = 1, adsc_n = 1, adv_n = 1, burst_lin = 0;
  logic gw_n = 1, bwe_n = 1;
  logic [1:0] bsel_n = 2'b11;
  logic busy;
  logic [AW-1:0] cur_addr;
  logic [1:0] lane_we;
  logic [DW-1:0] rdata;

  logic [DW-1:0] model [64];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  burst_sram_front u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce1_n(ce1_n),
    .ce2(ce2), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .burst_lin(burst_lin),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .busy(busy), .cur_addr(cur_addr),
    .lane_we(lane_we), .rdata(rdata));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1;
    gw_n = 1; bwe_n = 1; bsel_n = 2'b11;
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw, input logic [1:0] ln);
    logic [DW-1:0] r = old;
    if (ln[0]) r[8:0]  = nw[8:0];
    if (ln[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1600000;
    checks++; errors++;
    $display("FAIL watchdog: got hang expected finish");
    summary();
  end

  initial begin
    idle();
    #2; cyc(); cyc();
    chk("R1 busy", busy, 0);
    chk("R1 cur_addr", cur_addr, 0);
    chk("R1 lane_we", lane_we, 0);
    rst_n = 1;

    // fill every word with global write through the controller-side strobe
    for (int a = 0; a < 64; a++) begin
      idle(); adsc_n = 0; gw_n = 0; bwe_n = a[0]; bsel_n = a[2:1];
      addr = AW'(a); wdata = DW'((a * 3371 + 17) & 18'h3ffff);
      cyc();
      model[a] = wdata;
      chk("R10 lane_we", lane_we, 3);
      chk("R3 cur_addr", cur_addr, a);
      chk("R11 rdata", rdata, model[a]);
    end

    // burst order sweep
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        idle(); burst_lin = lin[0]; adsp_n = 0; gw_n = 0; addr = AW'(20 + s); wdata = '1;
        cyc();
        chk("R2 cur_addr", cur_addr, 20 + s);
        chk("R2 lane_we", lane_we, 0);
        chk("R2 rdata", rdata, model[20 + s]);
        for (int k = 1; k <= 4; k++) begin
          int lo;
          idle(); adv_n = 0;
          cyc();
          lo = lin ? ((s + k) & 3) : (s ^ (k & 3));
          chk(lin ? "R8 cur_addr" : "R7 cur_addr", cur_addr, 20 + lo);
          chk("R11 rdata", rdata, model[20 + lo]);
        end
        chk("R8 wrap", cur_addr, 20 + s);
      end
    end
    burst_lin = 0;

    // write decode sweep
    for (int v = 0; v < 16; v++) begin
      logic [1:0] ln;
      idle(); adsc_n = 0; gw_n = v[3]; bwe_n = v[2]; bsel_n = v[1:0];
      addr = AW'(32 + v); wdata = DW'(18'h2a5a5 ^ (v * 777));
      ln = !v[3] ? 2'b11 : (!v[2] ? ~v[1:0] : 2'b00);
      cyc();
      model[32 + v] = merge(model[32 + v], wdata, ln);
      chk(v[3] ? "R9 lane_we" : "R10 lane_we", lane_we, ln);
      chk("R9 rdata", rdata, model[32 + v]);
    end

    // processor-side strobe with write controls: still a read
    idle(); adsp_n = 0; gw_n = 0; addr = 40; wdata = 0;
    cyc();
    chk("R2 lane_we", lane_we, 0);
    chk("R2 rdata", rdata, model[40]);
    chk("R2 busy", busy, 1);

    // both strobes: processor-side wins
    idle(); adsp_n = 0; adsc_n = 0; gw_n = 0; addr = 41; wdata = 0;
    cyc();
    chk("R4 cur_addr", cur_addr, 41);
    chk("R4 lane_we", lane_we, 0);
    chk("R4 rdata", rdata, model[41]);

    // processor-side strobe ignored with ce1_n high
    idle(); adsp_n = 0; ce1_n = 1; addr = 10;
    cyc();
    chk("R4 ignored addr", cur_addr, 41);
    chk("R4 ignored busy", busy, 1);

    // suspend: no strobe, no advance, write controls active
    idle(); gw_n = 0; wdata = 0;
    cyc();
    chk("R6 hold addr", cur_addr, 41);
    chk("R6 hold lane_we", lane_we, 0);
    chk("R6 hold rdata", rdata, model[41]);

    // advance with global write (interleaved: 41 -> 40)
    idle(); adv_n = 0; gw_n = 0; wdata = 18'h1b00d;
    cyc();
    model[40] = wdata;
    chk("R6 adv addr", cur_addr, 40);
    chk("R6 adv lane_we", lane_we, 3);
    chk("R6 adv rdata", rdata, model[40]);

    // deselect via ce2 low on controller-side strobe
    idle(); adsc_n = 0; ce2 = 0; gw_n = 0; addr = 50; wdata = 0;
    cyc();
    chk("R5 busy", busy, 0);
    chk("R5 lane_we", lane_we, 0);
    idle(); adv_n = 0; gw_n = 0; wdata = 0;
    cyc();
    chk("R5 adv busy", busy, 0);
    chk("R5 adv addr", cur_addr, 50);
    chk("R5 adv lane_we", lane_we, 0);
    chk("R5 rdata", rdata, model[50]);

    // deselect via processor-side strobe with ce2 low
    idle(); adsc_n = 0; addr = 52; cyc();
    chk("R3 busy", busy, 1);
    idle(); adsp_n = 0; ce2 = 0; addr = 53; cyc();
    chk("R5 p busy", busy, 0);

    // controller-side strobe with ce1_n high
    idle(); adsc_n = 0; adsp_n = 0; ce1_n = 1; gw_n = 0; addr = 54; cyc();
    chk("R5 ce1 busy", busy, 0);
    chk("R5 ce1 lane_we", lane_we, 0);
    chk("R5 ce1 rdata", rdata, model[54]);

    idle();
    summary();
  end
endmodule